// File: doc/BRIEF.md
# Relocatable host chip-select decoder

This block watches a 16-bit host I/O address and produces three active-low chip selects. One goes to a real-time clock, one to a keyboard-controller channel and one to a power-management channel. Each target has a base address that software can move. The base is held as a high byte and a low byte in a small configuration register file. Each decoded window drops one address bit from its compare, so it covers two ports. The clock window drops bit 0, which gives two consecutive ports. The keyboard and power windows drop bit 2, which gives the base and base+4.

An enable register gates each chip select. A lock register freezes a window's base and its enable bit until the next reset. The enable defaults come from a strap pin that is sampled while reset is held. Software reaches all eight configuration registers through a simple write port and a combinational read port. The chip selects are combinational from the host address and its valid strobe.

Top module: `hcs_decoder`

## Requirements
- R1: The configuration indices are 0 clock base high, 1 clock base low, 2 keyboard base high, 3 keyboard base low, 4 power base high, 5 power base low, 6 enable, 7 lock. A high byte holds address bits 15..8 and a low byte holds bits 7..0. After reset the bases read 0070h (clock), 0060h (keyboard) and 0062h (power).
- R2: If strap_en is 0 during reset, the enable register resets to 00h. If strap_en is 1, it resets to 07h.
- R3: rtc_cs_n is 0 exactly when the address equals the clock base with bit 0 ignored. With the default base, 0070h and 0071h select it and 0072h does not.
- R4: kbc_cs_n and pm_cs_n are 0 when the address equals their base or their base+4, with bit 2 ignored. With the default bases, 0060h and 0064h select the keyboard, 0062h and 0066h select power, and 0061h selects neither.
- R5: A chip select can be 0 only while its enable bit is 1. Enable bit 0 is the clock, bit 1 the keyboard and bit 2 power.
- R6: All three chip selects are 1 while host_valid is 0.
- R7: In each low byte the ignored bit (bit 0 for the clock, bit 2 for keyboard and power) always reads 0. Writes to that bit are dropped.
- R8: Writing a new base moves the window, so the old address no longer selects the target.
- R9: Lock bit 0 is the clock, bit 1 the keyboard and bit 2 power. While a lock bit is 1, writes to that window's base bytes and to its enable bit have no effect.
- R10: Writing the lock register can only set lock bits. A lock bit clears only on reset.
- R11: Bits 7..3 of the enable and lock registers read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_en | input | 1 | Strap that sets the enable defaults during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_idx |
| host_addr | input | 16 | Host I/O address |
| host_valid | input | 1 | Host address valid strobe |
| rtc_cs_n | output | 1 | Real-time clock chip select, active low |
| kbc_cs_n | output | 1 | Keyboard channel chip select, active low |
| pm_cs_n | output | 1 | Power-management channel chip select, active low |

## Verification
The decoder is driven with each window's base and its partner port, and with a neighbouring address that differs in a bit that is compared. This separates the correct ignored bit from a wrong one and from a mask that is too wide. The addresses are also presented with the strobe low and with individual enable bits cleared, which shows that gating is per window and not shared. Relocation and lock tests write all-ones and reserved-bit patterns. The read-back then shows which bits are kept, which are forced to zero and which are frozen by a lock.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int NWIN = 3;

  typedef enum logic [2:0] {
    IDX_RTC_HI = 3'd0,
    IDX_RTC_LO = 3'd1,
    IDX_KBD_HI = 3'd2,
    IDX_KBD_LO = 3'd3,
    IDX_PM_HI  = 3'd4,
    IDX_PM_LO  = 3'd5,
    IDX_EN     = 3'd6,
    IDX_LOCK   = 3'd7
  } cfg_idx_e;

  // Reset base address of each window: 0 clock, 1 keyboard, 2 power.
  function automatic logic [15:0] win_reset_base(int w);
    case (w)
      0:       return 16'h0070;
      1:       return 16'h0060;
      default: return 16'h0062;
    endcase
  endfunction

  // Address bit that is dropped from the compare of each window.
  function automatic logic [15:0] win_ign_mask(int w);
    return (w == 0) ? 16'h0001 : 16'h0004;
  endfunction
endpackage

// File: rtl/hcs_win_reg.sv
module hcs_win_reg #(
  parameter int ADDR_W = 16,
  parameter int REG_W = 8,
  parameter logic [ADDR_W-1:0] RST_BASE = '0,
  parameter logic [ADDR_W-1:0] IGN_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [REG_W-1:0]  wdata,
  output logic [ADDR_W-1:0] base
);
  localparam logic [REG_W-1:0] LO_KEEP = ~IGN_MASK[REG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= RST_BASE & ~IGN_MASK;
    end else if (!lock) begin
      if (wr_hi) base[ADDR_W-1:REG_W] <= wdata;
      if (wr_lo) base[REG_W-1:0] <= wdata & LO_KEEP;
    end
  end
endmodule

// File: rtl/hcs_win_match.sv
module hcs_win_match #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IGN_MASK = '0
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  input  logic              en,
  output logic              cs_n
);
  logic hit;

  always_comb begin
    hit  = ((addr & ~IGN_MASK) == (base & ~IGN_MASK));
    cs_n = ~(valid & en & hit);
  end
endmodule

// File: rtl/hcs_ctl_regs.sv
module hcs_ctl_regs #(
  parameter int NWIN = 3,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap,
  input  logic             we_en,
  input  logic             we_lock,
  input  logic [REG_W-1:0] wdata,
  output logic [NWIN-1:0]  en_q,
  output logic [NWIN-1:0]  lock_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= strap ? '1 : '0;
      lock_q <= '0;
    end else begin
      if (we_en) begin
        for (int i = 0; i < NWIN; i++) begin
          if (!lock_q[i]) en_q[i] <= wdata[i];
        end
      end
      if (we_lock) lock_q <= lock_q | wdata[NWIN-1:0];
    end
  end
endmodule

// File: rtl/hcs_decoder.sv
module hcs_decoder #(
  parameter int ADDR_W = 16,
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_en,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_valid,
  output logic              rtc_cs_n,
  output logic              kbc_cs_n,
  output logic              pm_cs_n
);
  import hcs_pkg::*;

  logic [ADDR_W-1:0] base_q [NWIN];
  logic [NWIN-1:0]   en_q;
  logic [NWIN-1:0]   lock_q;
  logic [NWIN-1:0]   cs_n;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic wr_hi, wr_lo;
    assign wr_hi = cfg_we && (cfg_idx == 3'(2 * w));
    assign wr_lo = cfg_we && (cfg_idx == 3'(2 * w + 1));

    hcs_win_reg #(
      .ADDR_W(ADDR_W), .REG_W(REG_W),
      .RST_BASE(win_reset_base(w)), .IGN_MASK(win_ign_mask(w))
    ) i_reg (
      .clk(clk), .rst(rst), .lock(lock_q[w]),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(cfg_wdata), .base(base_q[w])
    );

    hcs_win_match #(
      .ADDR_W(ADDR_W), .IGN_MASK(win_ign_mask(w))
    ) i_match (
      .base(base_q[w]), .addr(host_addr), .valid(host_valid),
      .en(en_q[w]), .cs_n(cs_n[w])
    );
  end

  hcs_ctl_regs #(.NWIN(NWIN), .REG_W(REG_W)) i_ctl (
    .clk(clk), .rst(rst), .strap(strap_en),
    .we_en(cfg_we && cfg_idx == IDX_EN),
    .we_lock(cfg_we && cfg_idx == IDX_LOCK),
    .wdata(cfg_wdata), .en_q(en_q), .lock_q(lock_q)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx == IDX_EN) begin
      cfg_rdata[NWIN-1:0] = en_q;
    end else if (cfg_idx == IDX_LOCK) begin
      cfg_rdata[NWIN-1:0] = lock_q;
    end else begin
      for (int w = 0; w < NWIN; w++) begin
        if (cfg_idx == 3'(2 * w))     cfg_rdata = base_q[w][ADDR_W-1:REG_W];
        if (cfg_idx == 3'(2 * w + 1)) cfg_rdata = base_q[w][REG_W-1:0];
      end
    end
  end

  assign rtc_cs_n = cs_n[0];
  assign kbc_cs_n = cs_n[1];
  assign pm_cs_n  = cs_n[2];
endmodule

// File: rtl/hcs_decoder_chk.sv
module hcs_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        strap_en,
  input logic        host_valid,
  input logic [15:0] host_addr,
  input logic        rtc_cs_n,
  input logic        kbc_cs_n,
  input logic        pm_cs_n,
  input logic [2:0]  en_q,
  input logic [2:0]  lock_q,
  input logic [15:0] base0,
  input logic [15:0] base1,
  input logic [15:0] base2
);
  p_strap_reset_r2: assert property (@(posedge clk)
    rst |=> (en_q == ($past(strap_en) ? 3'b111 : 3'b000)));

  p_rtc_match_r3: assert property (@(posedge clk) disable iff (rst)
    !rtc_cs_n |-> (host_addr[15:1] == base0[15:1]));

  p_pair_match_r4: assert property (@(posedge clk) disable iff (rst)
    (!kbc_cs_n || !pm_cs_n) |->
      ((kbc_cs_n || ((host_addr & 16'hFFFB) == base1)) &&
       (pm_cs_n  || ((host_addr & 16'hFFFB) == base2))));

  p_cs_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    (!rtc_cs_n || !kbc_cs_n || !pm_cs_n) |->
      ((rtc_cs_n || en_q[0]) && (kbc_cs_n || en_q[1]) && (pm_cs_n || en_q[2])));

  p_idle_high_r6: assert property (@(posedge clk) disable iff (rst)
    !host_valid |-> (rtc_cs_n && kbc_cs_n && pm_cs_n));

  p_ign_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (base0[0] == 1'b0) && (base1[2] == 1'b0) && (base2[2] == 1'b0));

  p_locked_base_r9: assert property (@(posedge clk) disable iff (rst)
    (lock_q != 3'b000) |=>
      ((!$past(lock_q[0]) || $stable(base0)) &&
       (!$past(lock_q[1]) || $stable(base1)) &&
       (!$past(lock_q[2]) || $stable(base2))));

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (lock_q != 3'b000) |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
endmodule

bind hcs_decoder hcs_decoder_chk i_chk (
  .clk(clk), .rst(rst), .strap_en(strap_en), .host_valid(host_valid),
  .host_addr(host_addr), .rtc_cs_n(rtc_cs_n), .kbc_cs_n(kbc_cs_n),
  .pm_cs_n(pm_cs_n), .en_q(en_q), .lock_q(lock_q),
  .base0(base_q[0]), .base1(base_q[1]), .base2(base_q[2])
);

// File: tb/test_hcs_decoder.sv
module test_hcs_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [7:0]  cfg_wdata = 8'd0;
  logic [7:0]  cfg_rdata;
  logic [15:0] host_addr = 16'd0;
  logic        host_valid = 1'b0;
  logic        rtc_cs_n, kbc_cs_n, pm_cs_n;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hcs_decoder i_hcs_decoder (
    .clk(clk), .rst(rst), .strap_en(strap_en), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .host_addr(host_addr), .host_valid(host_valid),
    .rtc_cs_n(rtc_cs_n), .kbc_cs_n(kbc_cs_n), .pm_cs_n(pm_cs_n)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1;
    strap_en = s;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_idx = idx;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] idx, input logic [7:0] exp);
    cfg_idx = idx;
    #1;
    check(tag, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  // Expected value is {rtc, kbc, pm} chip selects.
  task automatic cs(input string tag, input logic [15:0] a, input logic v, input logic [2:0] exp);
    host_addr = a;
    host_valid = v;
    #1;
    check(tag, {13'd0, rtc_cs_n, kbc_cs_n, pm_cs_n}, {13'd0, exp});
    host_valid = 1'b0;
  endtask

  task automatic t_reset_strap0;
    do_reset(1'b0);
    rd("R1 rtc hi", 3'd0, 8'h00);
    rd("R1 rtc lo", 3'd1, 8'h70);
    rd("R1 kbd hi", 3'd2, 8'h00);
    rd("R1 kbd lo", 3'd3, 8'h60);
    rd("R1 pm hi", 3'd4, 8'h00);
    rd("R1 pm lo", 3'd5, 8'h62);
    rd("R2 enable strap0", 3'd6, 8'h00);
    rd("R10 lock reset", 3'd7, 8'h00);
    cs("R5 rtc disabled", 16'h0070, 1'b1, 3'b111);
    cs("R5 kbd disabled", 16'h0060, 1'b1, 3'b111);
  endtask

  task automatic t_reset_strap1;
    do_reset(1'b1);
    rd("R2 enable strap1", 3'd6, 8'h07);
  endtask

  task automatic t_decode;
    cs("R3 rtc base", 16'h0070, 1'b1, 3'b011);
    cs("R3 rtc base+1", 16'h0071, 1'b1, 3'b011);
    cs("R3 rtc 0072", 16'h0072, 1'b1, 3'b111);
    cs("R3 rtc 0170", 16'h0170, 1'b1, 3'b111);
    cs("R4 kbd 0060", 16'h0060, 1'b1, 3'b101);
    cs("R4 kbd 0064", 16'h0064, 1'b1, 3'b101);
    cs("R4 pm 0062", 16'h0062, 1'b1, 3'b110);
    cs("R4 pm 0066", 16'h0066, 1'b1, 3'b110);
    cs("R4 none 0061", 16'h0061, 1'b1, 3'b111);
    cs("R4 none 0068", 16'h0068, 1'b1, 3'b111);
    cs("R6 strobe low rtc", 16'h0070, 1'b0, 3'b111);
    cs("R6 strobe low kbd", 16'h0064, 1'b0, 3'b111);
  endtask

  task automatic t_enable;
    wr(3'd6, 8'h05);
    cs("R5 kbd off", 16'h0060, 1'b1, 3'b111);
    cs("R5 rtc on", 16'h0070, 1'b1, 3'b011);
    cs("R5 pm on", 16'h0066, 1'b1, 3'b110);
    wr(3'd6, 8'h07);
  endtask

  task automatic t_ignored_bit;
    wr(3'd1, 8'hFF);
    rd("R7 rtc lo bit0", 3'd1, 8'hFE);
    wr(3'd3, 8'hFF);
    rd("R7 kbd lo bit2", 3'd3, 8'hFB);
    wr(3'd5, 8'h66);
    rd("R7 pm lo bit2", 3'd5, 8'h62);
    wr(3'd1, 8'h70);
    wr(3'd3, 8'h60);
  endtask

  task automatic t_relocate;
    wr(3'd4, 8'h03);
    wr(3'd5, 8'h40);
    cs("R8 pm new", 16'h0340, 1'b1, 3'b110);
    cs("R8 pm new+4", 16'h0344, 1'b1, 3'b110);
    cs("R8 pm old", 16'h0062, 1'b1, 3'b111);
  endtask

  task automatic t_lock;
    wr(3'd7, 8'h01);
    wr(3'd0, 8'h12);
    rd("R9 rtc hi locked", 3'd0, 8'h00);
    wr(3'd1, 8'h20);
    rd("R9 rtc lo locked", 3'd1, 8'h70);
    wr(3'd6, 8'h00);
    rd("R9 enable partly locked", 3'd6, 8'h01);
    cs("R9 rtc still decodes", 16'h0071, 1'b1, 3'b011);
    wr(3'd2, 8'h01);
    rd("R9 kbd hi unlocked", 3'd2, 8'h01);
  endtask

  task automatic t_lock_sticky;
    wr(3'd7, 8'h00);
    rd("R10 lock not cleared", 3'd7, 8'h01);
    wr(3'd7, 8'hFC);
    rd("R11 lock reserved", 3'd7, 8'h05);
    wr(3'd6, 8'hFA);
    rd("R11 enable reserved", 3'd6, 8'h03);
    do_reset(1'b1);
    rd("R10 lock cleared by reset", 3'd7, 8'h00);
    rd("R8 pm base restored", 3'd5, 8'h62);
  endtask

  initial begin
    t_reset_strap0();
    t_reset_strap1();
    t_decode();
    t_enable();
    t_ignored_bit();
    t_relocate();
    t_lock();
    t_lock_sticky();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule